// File: doc/BRIEF.md
# Byte-Wide GPIO Pin Register Block

The block exposes a small byte-addressed register window for general-purpose pins. Software sees two groups in a 48-byte window. The first eight bytes are read-only level bytes, which read as zero here. Next comes one control byte for each of 36 pins, and the last four bytes are unused. Each control byte holds three meaningful fields:

- an output-enable flag;
- an output value;
- an observed level, taken either from the pin pad or, while the output is enabled, from the value software writes.

Changes on the pad inputs are detected cycle by cycle and folded into the observed-level field. Two pins are tied to interrupt outputs with fixed polarity:

- **Pin 1** raises its line while its level is low.
- **Pin 9** raises its line while its level is high. A request on the non-maskable input drives pin 9 high for one cycle and then low, so its line pulses once.

Two one-cycle status outputs report pad events on other pins and pad events on a pin that is driving its output. No other interrupt routing exists.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After synchronous reset, every pin control byte reads 0x00, except pin 1, which reads 0x02. Both interrupt outputs and both status pulses are low.
- R2: Reads of offsets 0 to 7 and 44 to 47 return 0x00. Writes to those offsets change no pin control byte.
- R3: Offset 8+i reads and writes the control byte of pin i. Bits 7..3, bit 2 (output enable) and bit 0 (output value) keep the written value.
- R4: On a write, the written bit 1 is discarded. If the written bit 2 is 1, the stored bit 1 becomes the written bit 0. Otherwise the stored bit 1 keeps its old value.
- R5: A change on pad_in[i] sets bit 1 of pin i to the new pad level at the next clock edge and leaves the other bits alone. If bit 2 of that byte is 1 at that time, err_drive pulses high for one cycle after that edge, and the update still happens.
- R6: When a pad event changes the stored byte of pin 1, irq_low_pin goes to the inverse of the new level at that edge. A pad event that leaves a byte unchanged does not alter either interrupt output.
- R7: When an event changes the stored byte of pin 9, irq_pulse_pin goes to the new level. An nmi_req pulse produced at edge k applies level 1 to pin 9 at edge k+1 and level 0 at edge k+2, giving a one-cycle pulse on irq_pulse_pin.
- R8: A pad event that changes the byte of any pin other than 1 and 9 pulses unimpl_evt high for one cycle after the edge.
- R9: If a write and a pad event reach the same pin in the same cycle, the write is applied first and the pad level then overrides bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Byte access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pad_in | input | 36 | External pin levels |
| nmi_req | input | 1 | Non-maskable request, one cycle high |
| irq_low_pin | output | 1 | Pin 1 interrupt, active while level is low |
| irq_pulse_pin | output | 1 | Pin 9 interrupt, follows level |
| err_drive | output | 1 | One-cycle pulse: pad event on an output-enabled pin |
| unimpl_evt | output | 1 | One-cycle pulse: changing event on an unrouted pin |

## Verification
Every pin receives all 256 write values. Running these in sequence separates the output-enable copy of bit 1 from the keep-previous case, and exposes any address-to-pin mix-up. Every pin then sees a pad toggle with output enable clear and set, which tells apart the error pulse, the unrouted-pin pulse and the two interrupt polarities. Targeted cases cover the following:
- a pad event that leaves a byte unchanged;
- the two-phase non-maskable pulse on pin 9, with its cycle timing;
- a write and a pad event colliding on the same pin in one cycle;
- writes to the read-only and unused offsets.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;

    localparam int PKG_NPINS     = 36;
    localparam int PKG_LVL_BYTES = 8;
    localparam int PKG_WIN_BYTES = 48;

    localparam int PIN_LOW_IRQ   = 1;
    localparam int PIN_PULSE_IRQ = 9;

    localparam int OUT_BIT = 0;
    localparam int LVL_BIT = 1;
    localparam int OE_BIT  = 2;

    typedef enum logic [1:0] {
        RGN_LEVEL = 2'd0,
        RGN_PIN   = 2'd1,
        RGN_SPARE = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        NMI_IDLE = 2'd0,
        NMI_HIGH = 2'd1,
        NMI_LOW  = 2'd2
    } nmi_phase_e;

    typedef struct packed {
        logic valid;
        logic level;
    } pad_evt_t;

    function automatic logic [7:0] pin_rst_val(int idx);
        return (idx == PIN_LOW_IRQ) ? 8'h02 : 8'h00;
    endfunction

    function automatic logic [7:0] merge_write(logic [7:0] old_b, logic [7:0] wd);
        logic [7:0] nb;
        nb = wd;
        nb[LVL_BIT] = wd[OE_BIT] ? wd[OUT_BIT] : old_b[LVL_BIT];
        return nb;
    endfunction

    function automatic logic [7:0] merge_level(logic [7:0] base, logic lvl);
        logic [7:0] nb;
        nb = base;
        nb[LVL_BIT] = lvl;
        return nb;
    endfunction

endpackage

// File: rtl/gpio_bus_dec.sv
module gpio_bus_dec
    import gpio_pin_pkg::*;
#(
    parameter int NUM_PINS  = PKG_NPINS,
    parameter int LVL_BYTES = PKG_LVL_BYTES,
    parameter int WIN_BYTES = PKG_WIN_BYTES,
    localparam int AW = $clog2(WIN_BYTES),
    localparam int PW = $clog2(NUM_PINS)
) (
    input  logic [AW-1:0] addr,
    output region_e       region,
    output logic [PW-1:0] pin_idx
);
    always_comb begin
        pin_idx = PW'(32'(addr) - LVL_BYTES);
        if (32'(addr) < LVL_BYTES)
            region = RGN_LEVEL;
        else if (32'(addr) < LVL_BYTES + NUM_PINS)
            region = RGN_PIN;
        else
            region = RGN_SPARE;
    end
endmodule

// File: rtl/gpio_evt_gen.sv
module gpio_evt_gen
    import gpio_pin_pkg::*;
#(
    parameter int NUM_PINS = PKG_NPINS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic                nmi_req,
    output pad_evt_t [NUM_PINS-1:0] evt
);
    logic [NUM_PINS-1:0] pad_q;
    nmi_phase_e          phase_q;

    function automatic logic [NUM_PINS-1:0] pad_rst_val();
        logic [NUM_PINS-1:0] v;
        for (int i = 0; i < NUM_PINS; i++) v[i] = pin_rst_val(i)[LVL_BIT];
        return v;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            pad_q   <= pad_rst_val();
            phase_q <= NMI_IDLE;
        end else begin
            pad_q <= pad_in;
            case (phase_q)
                NMI_IDLE: if (nmi_req) phase_q <= NMI_HIGH;
                NMI_HIGH: phase_q <= NMI_LOW;
                default:  phase_q <= NMI_IDLE;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_evt
        if (i == PIN_PULSE_IRQ) begin : g_nmi_pin
            always_comb begin
                if (phase_q != NMI_IDLE) begin
                    evt[i].valid = 1'b1;
                    evt[i].level = (phase_q == NMI_HIGH);
                end else begin
                    evt[i].valid = pad_in[i] ^ pad_q[i];
                    evt[i].level = pad_in[i];
                end
            end
        end else begin : g_plain_pin
            always_comb begin
                evt[i].valid = pad_in[i] ^ pad_q[i];
                evt[i].level = pad_in[i];
            end
        end
    end

    p_nmi_seq_r7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == NMI_HIGH) |=> (phase_q == NMI_LOW));
endmodule

// File: rtl/gpio_pin_file.sv
module gpio_pin_file
    import gpio_pin_pkg::*;
#(
    parameter int NUM_PINS = PKG_NPINS,
    localparam int PW = $clog2(NUM_PINS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [PW-1:0]            wr_idx,
    input  logic [7:0]               wdata,
    input  pad_evt_t [NUM_PINS-1:0]  evt,
    output logic [NUM_PINS-1:0][7:0] regs_q,
    output logic [NUM_PINS-1:0]      changed,
    output logic [NUM_PINS-1:0]      oe_hit
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic       hit_w;
        logic [7:0] base_b;
        logic [7:0] next_b;

        always_comb begin
            hit_w      = wr_en && (wr_idx == PW'(i));
            base_b     = hit_w ? merge_write(regs_q[i], wdata) : regs_q[i];
            next_b     = evt[i].valid ? merge_level(base_b, evt[i].level) : base_b;
            changed[i] = evt[i].valid && (next_b != base_b);
            oe_hit[i]  = evt[i].valid && base_b[OE_BIT];
        end

        always_ff @(posedge clk) begin
            if (rst) regs_q[i] <= pin_rst_val(i);
            else     regs_q[i] <= next_b;
        end

        p_keep_lvl_r4: assert property (@(posedge clk) disable iff (rst)
            (hit_w && !wdata[OE_BIT] && !evt[i].valid)
            |=> (regs_q[i][LVL_BIT] == $past(regs_q[i][LVL_BIT])));

        p_oe_copy_r4: assert property (@(posedge clk) disable iff (rst)
            (hit_w && wdata[OE_BIT] && !evt[i].valid)
            |=> (regs_q[i][LVL_BIT] == $past(wdata[OUT_BIT])));

        p_evt_lvl_only_r5: assert property (@(posedge clk) disable iff (rst)
            (evt[i].valid && !hit_w)
            |=> (((regs_q[i] ^ $past(regs_q[i])) & 8'hFD) == 8'h00)
                && (regs_q[i][LVL_BIT] == $past(evt[i].level)));
    end
endmodule

// File: rtl/gpio_irq_out.sv
module gpio_irq_out
    import gpio_pin_pkg::*;
#(
    parameter int NUM_PINS = PKG_NPINS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  pad_evt_t [NUM_PINS-1:0] evt,
    input  logic [NUM_PINS-1:0]     changed,
    input  logic [NUM_PINS-1:0]     oe_hit,
    output logic                    irq_low_pin,
    output logic                    irq_pulse_pin,
    output logic                    err_drive,
    output logic                    unimpl_evt
);
    localparam logic [NUM_PINS-1:0] ROUTED =
        (NUM_PINS'(1) << PIN_LOW_IRQ) | (NUM_PINS'(1) << PIN_PULSE_IRQ);

    logic [NUM_PINS-1:0] lvl_vec;
    always_comb
        for (int i = 0; i < NUM_PINS; i++) lvl_vec[i] = evt[i].level;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_low_pin   <= 1'b0;
            irq_pulse_pin <= 1'b0;
            err_drive     <= 1'b0;
            unimpl_evt    <= 1'b0;
        end else begin
            if (changed[PIN_LOW_IRQ])   irq_low_pin   <= ~lvl_vec[PIN_LOW_IRQ];
            if (changed[PIN_PULSE_IRQ]) irq_pulse_pin <= lvl_vec[PIN_PULSE_IRQ];
            err_drive  <= |oe_hit;
            unimpl_evt <= |(changed & ~ROUTED);
        end
    end

    p_irq_low_pol_r6: assert property (@(posedge clk) disable iff (rst)
        changed[PIN_LOW_IRQ] |=> (irq_low_pin == !$past(lvl_vec[PIN_LOW_IRQ])));

    p_irq_low_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !changed[PIN_LOW_IRQ] |=> $stable(irq_low_pin));

    p_irq_pulse_pol_r7: assert property (@(posedge clk) disable iff (rst)
        changed[PIN_PULSE_IRQ] |=> (irq_pulse_pin == $past(lvl_vec[PIN_PULSE_IRQ])));

    p_unimpl_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (|(changed & ~ROUTED)) |=> unimpl_evt);
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pin_pkg::*;
#(
    parameter int NUM_PINS  = PKG_NPINS,
    parameter int LVL_BYTES = PKG_LVL_BYTES,
    parameter int WIN_BYTES = PKG_WIN_BYTES,
    localparam int AW = $clog2(WIN_BYTES),
    localparam int PW = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [AW-1:0]       bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic                nmi_req,
    output logic                irq_low_pin,
    output logic                irq_pulse_pin,
    output logic                err_drive,
    output logic                unimpl_evt
);
    region_e                  region;
    logic [PW-1:0]            pin_idx;
    pad_evt_t [NUM_PINS-1:0]  evt;
    logic [NUM_PINS-1:0][7:0] regs_q;
    logic [NUM_PINS-1:0]      changed;
    logic [NUM_PINS-1:0]      oe_hit;
    logic                     pin_wr;

    gpio_bus_dec #(.NUM_PINS(NUM_PINS), .LVL_BYTES(LVL_BYTES), .WIN_BYTES(WIN_BYTES)) dec_i (
        .addr(bus_addr), .region(region), .pin_idx(pin_idx));

    gpio_evt_gen #(.NUM_PINS(NUM_PINS)) evt_i (
        .clk(clk), .rst(rst), .pad_in(pad_in), .nmi_req(nmi_req), .evt(evt));

    assign pin_wr = bus_sel && bus_wr && (region == RGN_PIN);

    gpio_pin_file #(.NUM_PINS(NUM_PINS)) file_i (
        .clk(clk), .rst(rst), .wr_en(pin_wr), .wr_idx(pin_idx), .wdata(bus_wdata),
        .evt(evt), .regs_q(regs_q), .changed(changed), .oe_hit(oe_hit));

    gpio_irq_out #(.NUM_PINS(NUM_PINS)) irq_i (
        .clk(clk), .rst(rst), .evt(evt), .changed(changed), .oe_hit(oe_hit),
        .irq_low_pin(irq_low_pin), .irq_pulse_pin(irq_pulse_pin),
        .err_drive(err_drive), .unimpl_evt(unimpl_evt));

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_sel && !bus_wr && region == RGN_PIN) bus_rdata = regs_q[pin_idx];
    end

    logic any_evt;
    always_comb begin
        any_evt = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) any_evt = any_evt | evt[i].valid;
    end

    p_spare_wr_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && region != RGN_PIN && !any_evt) |=> $stable(regs_q));
endmodule

// File: tb/gpio_pin_ctrl_tb_top.sv
module gpio_pin_ctrl_tb_top;
    localparam int NP = 36;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [NP-1:0] pad_in = 36'h2;
    logic        nmi_req = 1'b0;
    logic        irq_low_pin, irq_pulse_pin, err_drive, unimpl_evt;

    int nchk = 0, nfail = 0;
    bit done = 0;

    logic [7:0]    mdl [NP];
    logic [NP-1:0] pad_m = 36'h2;
    logic          irq1_m = 0, irq9_m = 0;

    always #2 clk = ~clk;

    gpio_pin_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .nmi_req(nmi_req),
        .irq_low_pin(irq_low_pin), .irq_pulse_pin(irq_pulse_pin),
        .err_drive(err_drive), .unimpl_evt(unimpl_evt));

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] wmerge(logic [7:0] o, logic [7:0] d);
        logic [7:0] n;
        n = d;
        n[1] = d[2] ? d[0] : o[1];
        return n;
    endfunction

    task automatic bus_write(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 6'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        if (a >= 8 && a < 8 + NP) mdl[a-8] = wmerge(mdl[a-8], d);
    endtask

    task automatic bus_read(input int a, output logic [7:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = 6'(a);
        #1 v = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic check_pin(input int i, input string tag);
        logic [7:0] v;
        bus_read(8 + i, v);
        check(v == mdl[i], tag, v, mdl[i]);
    endtask

    // flip one pad; check flags and interrupts one cycle later
    task automatic flip_pad(input int i, input string tag);
        logic [7:0] nb;
        logic v, err_e, un_e, ch;
        v = ~pad_m[i];
        @(negedge clk);
        pad_in[i] = v;
        err_e = mdl[i][2];
        nb = mdl[i]; nb[1] = v;
        ch = (nb != mdl[i]);
        mdl[i] = nb; pad_m[i] = v;
        un_e = ch && i != 1 && i != 9;
        if (ch && i == 1) irq1_m = ~v;
        if (ch && i == 9) irq9_m = v;
        @(negedge clk);
        check(err_drive == err_e, {tag, " R5 err_drive"}, err_drive, err_e);
        check(unimpl_evt == un_e, {tag, " R8 unimpl_evt"}, unimpl_evt, un_e);
        check(irq_low_pin == irq1_m, {tag, " R6 irq_low_pin"}, irq_low_pin, irq1_m);
        check(irq_pulse_pin == irq9_m, {tag, " R7 irq_pulse_pin"}, irq_pulse_pin, irq9_m);
        check_pin(i, {tag, " R5 pin byte"});
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < NP; i++) mdl[i] = (i == 1) ? 8'h02 : 8'h00;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        check(irq_low_pin == 0, "R1 irq_low_pin", irq_low_pin, 0);
        check(irq_pulse_pin == 0, "R1 irq_pulse_pin", irq_pulse_pin, 0);
        check(err_drive == 0 && unimpl_evt == 0, "R1 flags", {err_drive, unimpl_evt}, 0);
        for (int a = 0; a < 48; a++) begin
            logic [7:0] e;
            e = (a == 9) ? 8'h02 : 8'h00;
            bus_read(a, v);
            check(v == e, "R1 reset byte", v, e);
        end

        // R3/R4: every value into every pin
        for (int i = 0; i < NP; i++) begin
            for (int d = 0; d < 256; d++) begin
                bus_write(8 + i, 8'(d));
                check_pin(i, "R3 R4 write sweep");
            end
            bus_write(8 + i, 8'h00);
            check_pin(i, "R4 keep after sweep");
        end
        check(irq_low_pin == 0 && irq_pulse_pin == 0, "R6 writes leave irq",
              {irq_low_pin, irq_pulse_pin}, 0);

        // R2: read-only and spare offsets
        for (int a = 0; a < 48; a++) begin
            if (a < 8 || a >= 44) begin
                bus_write(a, 8'hFF);
                bus_read(a, v);
                check(v == 8'h00, "R2 ignored offset reads zero", v, 0);
            end
        end
        for (int i = 0; i < NP; i++) check_pin(i, "R2 pins untouched");

        // R5..R8: pad toggles with output enable clear and set
        for (int i = 0; i < NP; i++) begin
            for (int oe = 0; oe < 2; oe++) begin
                bus_write(8 + i, oe ? 8'h04 : 8'h00);
                flip_pad(i, "pad sweep");
                flip_pad(i, "pad sweep back");
            end
            bus_write(8 + i, 8'h00);
        end

        // R6/R7: unchanged byte takes no interrupt action
        if (pad_m[9]) flip_pad(9, "prep9");
        bus_write(8 + 9, 8'h05);
        check_pin(9, "R4 pin9 oe copy");
        flip_pad(9, "R7 unchanged event");
        check(irq_pulse_pin == 0, "R7 unchanged keeps irq", irq_pulse_pin, 0);
        flip_pad(9, "R7 pin9 low");
        bus_write(8 + 9, 8'h04);
        bus_write(8 + 9, 8'h00);
        if (pad_m[1] == 0) flip_pad(1, "prep1");
        bus_write(8 + 1, 8'h04);
        check(irq_low_pin == irq1_m, "R6 write no irq change", irq_low_pin, irq1_m);
        flip_pad(1, "R6 unchanged event");
        bus_write(8 + 1, 8'h00);

        // R7: NMI pulse timing
        @(negedge clk); nmi_req = 1;
        @(negedge clk); nmi_req = 0;
        check(irq_pulse_pin == 0, "R7 nmi k", irq_pulse_pin, 0);
        @(negedge clk);
        check(irq_pulse_pin == 1, "R7 nmi k+1 high", irq_pulse_pin, 1);
        @(negedge clk);
        check(irq_pulse_pin == 0, "R7 nmi k+2 low", irq_pulse_pin, 0);
        check(unimpl_evt == 0, "R8 nmi not unimpl", unimpl_evt, 0);
        check_pin(9, "R7 pin9 after nmi");

        // R9: write and pad event on one pin in one cycle
        if (pad_m[5] == 0) flip_pad(5, "prep5");
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 6'(13); bus_wdata = 8'h05;
        pad_in[5] = 0; pad_m[5] = 0;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        mdl[5] = 8'h05;
        check(err_drive == 1, "R9 err on collision", err_drive, 1);
        check(unimpl_evt == 1, "R9 unimpl on collision", unimpl_evt, 1);
        check_pin(5, "R9 pad overrides write");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule